// File: doc/BRIEF.md
# ISA Expansion Card Address Front End

This block sits on an expansion card's side of an ISA-style bus. It forms the card's view of each bus cycle's address and turns it into two select lines, one for the card's memory window and one for its I/O port window. The bus presents the top seven address bits early and unlatched, so a strobe register captures them. The low twenty bits stay valid for the whole command phase and are used directly.

The upper-bits register follows the bus while the latch strobe is high and freezes once the strobe falls. A 16-bit access that the host splits into two byte cycles issues the strobe only once, so the frozen value also serves the second cycle. Memory selection compares the full 24-bit address against a parameterised window. I/O selection compares the low port bits against a second window and is suppressed whenever the address-enable line is high, which marks DMA or refresh ownership of the bus. A refresh cycle selects nothing, because its low lines carry a row counter rather than a card address. Both selects are registered and track the command strobes.

Top module: `isa_card_decoder`

## Requirements
- R1: During reset, `mem_sel` and `io_sel` are 0 and `addr_lat[23:17]` is 0.
- R2: On every clock edge where `ale` is 1, the upper register loads `la_hi`. After that edge, `addr_lat[23:17]` equals the sampled `la_hi`.
- R3: While `ale` is 0, `addr_lat[23:17]` keeps its last loaded value whatever `la_hi` does. This covers the second byte cycle of a split 16-bit access.
- R4: `addr_lat[16:0]` always equals `sa_lo[16:0]`. `sa_lo[19:17]` is not used to form the address.
- R5: A clock edge that samples `memr_n` or `memw_n` at 0, `refresh_n` at 1 and `addr_lat` in [MEM_BASE, MEM_BASE+MEM_SIZE) sets `mem_sel` to 1 after that edge. Defaults: base 0x0D0000, size 0x10000.
- R6: An address one below the memory window or equal to its end never sets `mem_sel`. The same holds for an address that differs from the window only in bits 23:17.
- R7: A clock edge that samples `ior_n` or `iow_n` at 0, `aen` at 0, `refresh_n` at 1 and `sa_lo[15:0]` in [IO_BASE, IO_BASE+IO_SIZE) sets `io_sel` to 1 after that edge. Ports just outside the window do not set it. Defaults: base 0x300, size 0x10.
- R8: A clock edge that samples `aen` at 1 clears `io_sel`, even when the I/O window matches and an I/O command is active.
- R9: A clock edge that samples `refresh_n` at 0 clears both `mem_sel` and `io_sel`, whatever the address and commands.
- R10: The first clock edge that samples both strobes of a space inactive clears that space's select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| la_hi | input | 7 | Unlatched address bits 23:17 |
| sa_lo | input | 20 | Stable address bits 19:0 |
| ale | input | 1 | Address latch strobe, active high |
| aen | input | 1 | Address enable, high when DMA or refresh owns the bus |
| refresh_n | input | 1 | Refresh cycle indicator, active low |
| memr_n | input | 1 | Memory read command, active low |
| memw_n | input | 1 | Memory write command, active low |
| ior_n | input | 1 | I/O read command, active low |
| iow_n | input | 1 | I/O write command, active low |
| mem_sel | output | 1 | Registered memory window select |
| io_sel | output | 1 | Registered I/O window select |
| addr_lat | output | 24 | Latched upper bits joined with the low address bits |

## Verification
The hardest case to reach is a memory command whose upper bits come only from the held register. In that case `la_hi` has already moved on, just as in the second byte cycle of a split access. To build it, the bench pulses `ale` for one edge and then scrambles `la_hi` in the same half-cycle that the strobe drops. It then issues the command. A select that reads the live lines, or a register that ignores the strobe, decodes the wrong window. The bench also places addresses that differ only in the upper seven bits, so a decoder that skipped those bits would select.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

  // True when a lies in the half-open range [base, base+size).
  function automatic logic in_window(logic [31:0] a, logic [31:0] base, logic [31:0] size);
    logic [31:0] off;
    off = a - base;
    return (a >= base) && (off < size);
  endfunction

endpackage

// File: rtl/upper_addr_latch.sv
module upper_addr_latch #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (strobe) q <= d;
  end

  // R2: follows the bus while the strobe is high
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (q == $past(d)));
  // R3: frozen while the strobe is low
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(q));

endmodule

// File: rtl/window_match.sv
module window_match #(
  parameter int           AW   = 16,
  parameter logic [31:0]  BASE = 32'h300,
  parameter logic [31:0]  SIZE = 32'h10
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);

  logic [31:0] addr_ext;
  assign addr_ext = 32'(addr);
  assign hit = isa_dec_pkg::in_window(addr_ext, BASE, SIZE);

endmodule

// File: rtl/isa_card_decoder.sv
module isa_card_decoder #(
  parameter int              UP_W     = 7,
  parameter int              LO_W     = 20,
  parameter int              MEM_AW   = 24,
  parameter int              IO_AW    = 16,
  parameter logic [MEM_AW-1:0] MEM_BASE = 24'h0D0000,
  parameter logic [MEM_AW-1:0] MEM_SIZE = 24'h010000,
  parameter logic [IO_AW-1:0]  IO_BASE  = 16'h0300,
  parameter logic [IO_AW-1:0]  IO_SIZE  = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [UP_W-1:0]   la_hi,
  input  logic [LO_W-1:0]   sa_lo,
  input  logic              ale,
  input  logic              aen,
  input  logic              refresh_n,
  input  logic              memr_n,
  input  logic              memw_n,
  input  logic              ior_n,
  input  logic              iow_n,
  output logic              mem_sel,
  output logic              io_sel,
  output logic [MEM_AW-1:0] addr_lat
);

  localparam int KEEP_LO = MEM_AW - UP_W;

  logic [UP_W-1:0] hi_q;
  logic            mem_hit, io_hit;
  logic            mem_cmd, io_cmd, rfsh;
  logic            mem_go, io_go;

  upper_addr_latch #(.W(UP_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .strobe(ale), .d(la_hi), .q(hi_q)
  );

  assign addr_lat = {hi_q, sa_lo[KEEP_LO-1:0]};

  window_match #(.AW(MEM_AW), .BASE(32'(MEM_BASE)), .SIZE(32'(MEM_SIZE))) u_mem_win (
    .addr(addr_lat), .hit(mem_hit)
  );

  window_match #(.AW(IO_AW), .BASE(32'(IO_BASE)), .SIZE(32'(IO_SIZE))) u_io_win (
    .addr(sa_lo[IO_AW-1:0]), .hit(io_hit)
  );

  assign mem_cmd = !memr_n || !memw_n;
  assign io_cmd  = !ior_n  || !iow_n;
  assign rfsh    = !refresh_n;
  assign mem_go  = mem_hit && mem_cmd && !rfsh;
  assign io_go   = io_hit && io_cmd && !aen && !rfsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_sel <= 1'b0;
      io_sel  <= 1'b0;
    end else begin
      mem_sel <= mem_go;
      io_sel  <= io_go;
    end
  end

  // R9: refresh leaves both selects off
  a_r9_refresh_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh |=> (!mem_sel && !io_sel));
  // R8: bus owned by DMA/refresh keeps I/O select off
  a_r8_aen_blocks_io: assert property (@(posedge clk) disable iff (!rst_n)
    aen |=> !io_sel);
  // R10: selects drop one clock after their command ends
  a_r10_mem_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cmd |=> !mem_sel);
  a_r10_io_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !io_cmd |=> !io_sel);
  // R5: a memory select always follows an in-window command
  a_r5_mem_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sel) |-> $past(mem_hit && mem_cmd));

endmodule

// File: tb/test_isa_card_decoder.sv
module test_isa_card_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] MB = 24'h0D0000;
  localparam logic [23:0] MS = 24'h010000;
  localparam logic [15:0] IB = 16'h0300;
  localparam logic [15:0] IS = 16'h0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0]  la_hi = '0;
  logic [19:0] sa_lo = '0;
  logic ale = 1'b0, aen = 1'b0, refresh_n = 1'b1;
  logic memr_n = 1'b1, memw_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
  logic mem_sel, io_sel;
  logic [23:0] addr_lat;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_card_decoder i_isa_card_decoder (
    .clk(clk), .rst_n(rst_n), .la_hi(la_hi), .sa_lo(sa_lo), .ale(ale), .aen(aen),
    .refresh_n(refresh_n), .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n),
    .iow_n(iow_n), .mem_sel(mem_sel), .io_sel(io_sel), .addr_lat(addr_lat)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // aligned window: compare the bits above the window size
  function automatic logic exp_mem(logic [23:0] a);
    return ((a ^ MB) & ~(MS - 24'd1)) == 24'd0;
  endfunction
  function automatic logic exp_io(logic [15:0] p);
    return ((p ^ IB) & ~(IS - 16'd1)) == 16'd0;
  endfunction

  // strobe the upper bits for one edge, then scramble the live lines
  task automatic put_addr(logic [23:0] a);
    @(negedge clk);
    la_hi = a[23:17]; sa_lo = a[19:0]; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0; la_hi = ~a[23:17];
  endtask

  task automatic t_reset;
    check("R1 mem_sel", 32'(mem_sel), 0);
    check("R1 io_sel", 32'(io_sel), 0);
    check("R1 upper", 32'(addr_lat[23:17]), 0);
  endtask

  task automatic t_latch;
    put_addr(24'h8ABCDE);
    check("R2 capture", 32'(addr_lat[23:17]), 32'(7'h45));
    @(negedge clk); la_hi = 7'h12;
    @(negedge clk);
    check("R3 hold", 32'(addr_lat[23:17]), 32'(7'h45));
    sa_lo = 20'hE1234;
    #1 check("R4 low bits", 32'(addr_lat[16:0]), 32'(17'h01234));
  endtask

  task automatic t_mem(logic [23:0] a, logic use_wr, string req);
    put_addr(a);
    if (use_wr) memw_n = 1'b0; else memr_n = 1'b0;
    @(negedge clk);
    check(req, 32'(mem_sel), 32'(exp_mem(a)));
    memr_n = 1'b1; memw_n = 1'b1;
    @(negedge clk);
    check("R10 mem drop", 32'(mem_sel), 0);
  endtask

  task automatic t_io(logic [15:0] p, logic en, logic use_wr, string req);
    @(negedge clk);
    sa_lo = {4'h0, p}; aen = en;
    if (use_wr) iow_n = 1'b0; else ior_n = 1'b0;
    @(negedge clk);
    check(req, 32'(io_sel), 32'(exp_io(p) && !en));
    ior_n = 1'b1; iow_n = 1'b1;
    @(negedge clk);
    check("R10 io drop", 32'(io_sel), 0);
    aen = 1'b0;
  endtask

  task automatic t_refresh;
    put_addr(24'h0D0040);
    refresh_n = 1'b0; memr_n = 1'b0;
    @(negedge clk);
    check("R9 mem in refresh", 32'(mem_sel), 0);
    memr_n = 1'b1; sa_lo = 20'h00304; ior_n = 1'b0;
    @(negedge clk);
    check("R9 io in refresh", 32'(io_sel), 0);
    ior_n = 1'b1; refresh_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_latch;
    t_mem(24'h0D0000, 1'b0, "R5 base");
    t_mem(24'h0DFFFF, 1'b1, "R5 top");
    t_mem(24'h0CFFFF, 1'b0, "R6 below");
    t_mem(24'h0E0000, 1'b0, "R6 end");
    t_mem(24'h8D0000, 1'b1, "R6 upper differs");
    t_io(16'h0300, 1'b0, 1'b0, "R7 io base");
    t_io(16'h030F, 1'b0, 1'b1, "R7 io top");
    t_io(16'h0310, 1'b0, 1'b0, "R7 io end");
    t_io(16'h02FF, 1'b0, 1'b1, "R7 io below");
    t_io(16'h0305, 1'b1, 1'b0, "R8 aen high");
    t_refresh;
    t_mem(24'h0D1234, 1'b0, "R5 after refresh");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule